// File: doc/BRIEF.md
# Soft Interrupt Pending Register

This block keeps a 32-bit register of software-raised interrupt requests. A producer presents an operation code with a 64-bit data word. The operation can OR bits into the register, remove bits from it, or replace its contents. Only the low 32 bits of the data take part in any operation. At most one operation is taken per clock cycle.

After each clock edge the block reports whether that operation changed the register. It raises a change pulse for every change that takes effect. It also raises a recheck pulse that asks the interrupt controller to evaluate the pending set again, but only while interrupts are enabled. An operation that leaves the value as it was produces no pulse. The block does not prioritise or deliver interrupts.

The reset input is asynchronous and active low. The block releases it to its own logic two clock edges after the input goes high.

Top module: `soft_irq_pend`

## Requirements
- R1: Opcode 3'b001 (set) makes the register the bitwise OR of its old value and data bits [31:0]. Data bits [63:32] have no effect.
- R2: Opcode 3'b010 (clear) makes the register its old value AND the inverse of data bits [31:0].
- R3: Opcode 3'b011 (write) loads data bits [31:0] into the register.
- R4: When the computed value equals the current value, the register keeps its value and neither pulse is raised.
- R5: When an operation changes the register and irq_en_i is high in that same cycle, recheck_o is high for exactly the one cycle after the accepting edge. pend_o already shows the new value in that cycle.
- R6: chg_o is high for the one cycle after every edge that changes the register, whatever the level of irq_en_i. recheck_o stays low when irq_en_i was low.
- R7: While reset is active, the register reads zero and chg_o and recheck_o are low. After rst_ni rises, the internal logic leaves reset two rising edges later and no pulse is raised.
- R8: The opcodes 3'b000 and 3'b100 to 3'b111 are ignored. The register holds its value and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code: 001 set, 010 clear, 011 write, others idle |
| data_i | input | 64 | Operand; bits [31:0] are used |
| irq_en_i | input | 1 | Interrupt enable, gates the recheck pulse |
| pend_o | output | 32 | Current pending bits |
| chg_o | output | 1 | One-cycle pulse on an effective change |
| recheck_o | output | 1 | One-cycle request to re-evaluate interrupts |

## Verification
A wrong pending value shows on pend_o in the cycle right after the edge that took the operation, because the register drives the port directly. A faulty change comparison shows in that same cycle as a missing or extra pulse on chg_o. When interrupts are enabled, it also shows on recheck_o. A pulse that lasts too long or gets stuck shows one cycle later, so every directed test also samples the cycle after its operation.

// File: rtl/sip_pkg.sv
package sip_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    SIP_OP_IDLE = 3'b000,
    SIP_OP_SET  = 3'b001,
    SIP_OP_CLR  = 3'b010,
    SIP_OP_WR   = 3'b011
  } sip_op_e;
endpackage

// File: rtl/sip_rst_sync.sv
module sip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/sip_next_calc.sv
module sip_next_calc
  import sip_pkg::*;
#(
  parameter int unsigned PEND_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [PEND_W-1:0] opnd_i,
  input  logic [PEND_W-1:0] cur_i,
  output logic [PEND_W-1:0] cand_o,
  output logic              upd_o
);
  logic op_hit;

  always_comb begin
    op_hit = 1'b1;
    cand_o = cur_i;
    case (op_i)
      SIP_OP_SET: cand_o = cur_i | opnd_i;
      SIP_OP_CLR: cand_o = cur_i & ~opnd_i;
      SIP_OP_WR:  cand_o = opnd_i;
      default: begin
        op_hit = 1'b0;
        cand_o = cur_i;
      end
    endcase
    upd_o = op_hit && (cand_o != cur_i);
  end
endmodule

// File: rtl/sip_pend_reg.sv
module sip_pend_reg #(
  parameter int unsigned PEND_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PEND_W-1:0] d_i,
  output logic [PEND_W-1:0] q_o
);
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] pend_d;

  always_comb begin
    pend_d = pend_q;
    if (en_i) pend_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign q_o = pend_q;
endmodule

// File: rtl/sip_notify.sv
module sip_notify (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic irq_en_i,
  output logic chg_o,
  output logic recheck_o
);
  logic chg_q, chg_d;
  logic rck_q, rck_d;

  always_comb begin
    chg_d = upd_i;
    rck_d = upd_i & irq_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_q <= 1'b0;
      rck_q <= 1'b0;
    end else begin
      chg_q <= chg_d;
      rck_q <= rck_d;
    end
  end

  assign chg_o     = chg_q;
  assign recheck_o = rck_q;
endmodule

// File: rtl/soft_irq_pend.sv
module soft_irq_pend
  import sip_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned PEND_W    = 32,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              irq_en_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              chg_o,
  output logic              recheck_o
);
  localparam int unsigned HI_W = DATA_W - PEND_W;

  logic              rst_core_n;
  logic [PEND_W-1:0] opnd;
  logic [PEND_W-1:0] cand;
  logic              upd;
  logic [HI_W-1:0]   unused_data_hi;

  assign opnd           = data_i[PEND_W-1:0];
  assign unused_data_hi = data_i[DATA_W-1:PEND_W];

  sip_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_core_n)
  );

  sip_next_calc #(.PEND_W(PEND_W)) u_calc (
    .op_i  (op_i),
    .opnd_i(opnd),
    .cur_i (pend_o),
    .cand_o(cand),
    .upd_o (upd)
  );

  sip_pend_reg #(.PEND_W(PEND_W)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_core_n),
    .en_i  (upd),
    .d_i   (cand),
    .q_o   (pend_o)
  );

  sip_notify u_note (
    .clk_i    (clk_i),
    .rst_ni   (rst_core_n),
    .upd_i    (upd),
    .irq_en_i (irq_en_i),
    .chg_o    (chg_o),
    .recheck_o(recheck_o)
  );
endmodule

// File: rtl/sip_chk.sv
module sip_chk
  import sip_pkg::*;
#(
  parameter int unsigned PEND_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op,
  input logic [PEND_W-1:0] data,
  input logic              irq_en,
  input logic [PEND_W-1:0] pend,
  input logic              chg,
  input logic              recheck
);
  AST_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == SIP_OP_SET) |-> pend == ($past(pend) | $past(data))); // R1
  AST_CLR_ANDN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == SIP_OP_CLR) |-> pend == ($past(pend) & ~$past(data))); // R2
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op) == SIP_OP_WR) |-> pend == $past(data)); // R3
  AST_NO_DIFF_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && pend == $past(pend)) |-> !chg); // R4
  AST_RECHK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    recheck |-> (chg && $past(irq_en))); // R5
  AST_CHG_RECHK_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && $past(irq_en)) |-> recheck); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (pend == '0 && !chg && !recheck)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(op) == SIP_OP_IDLE || $past(op[2]))) |-> ($stable(pend) && !chg)); // R8
endmodule

bind soft_irq_pend sip_chk #(.PEND_W(PEND_W)) chk_i (
  .clk    (clk_i),
  .rst_n  (rst_core_n),
  .op     (op_i),
  .data   (data_i[PEND_W-1:0]),
  .irq_en (irq_en_i),
  .pend   (pend_o),
  .chg    (chg_o),
  .recheck(recheck_o)
);

// File: tb/soft_irq_pend_tb_top.sv
`timescale 1ns/1ps
module soft_irq_pend_tb_top;
  logic        clk;
  logic        rst_n;
  logic [2:0]  op;
  logic [63:0] data;
  logic        irq_en;
  logic [31:0] pend;
  logic        chg;
  logic        rck;

  int n_chk;
  int n_err;
  logic [31:0] exp_pend;

  soft_irq_pend dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .op_i     (op),
    .data_i   (data),
    .irq_en_i (irq_en),
    .pend_o   (pend),
    .chg_o    (chg),
    .recheck_o(rck)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act_p, input logic act_c,
                       input logic act_r, input logic [31:0] e_p, input logic e_c,
                       input logic e_r);
    n_chk++;
    if (act_p !== e_p || act_c !== e_c || act_r !== e_r) begin
      n_err++;
      $display("FAIL %s: actual pend=%h chg=%b rck=%b expected pend=%h chg=%b rck=%b",
               req, act_p, act_c, act_r, e_p, e_c, e_r);
    end
  endtask

  // Drive one operation, let one edge take it, sample in the following cycle.
  task automatic do_op(input logic [2:0] o, input logic [63:0] d, input logic en,
                       input string req, input logic [31:0] e_p, input logic e_c,
                       input logic e_r);
    @(negedge clk);
    op = o; data = d; irq_en = en;
    @(negedge clk);
    op = 3'b000; data = '1;
    check(req, pend, chg, rck, e_p, e_c, e_r);
    exp_pend = e_p;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 in reset", pend, chg, rck, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 after release", pend, chg, rck, 32'h0, 1'b0, 1'b0);
    exp_pend = '0;
  endtask

  task automatic t_set();
    do_op(3'b001, 64'hFFFF_0000_0000_00F0, 1'b1, "R1 set upper ignored", 32'h0000_00F0, 1'b1, 1'b1);
    @(negedge clk);
    check("R5 single-cycle pulse", pend, chg, rck, 32'h0000_00F0, 1'b0, 1'b0);
    do_op(3'b001, 64'h0000_0000_8000_000F, 1'b1, "R1 set merges", 32'h8000_00FF, 1'b1, 1'b1);
  endtask

  task automatic t_clear();
    do_op(3'b010, 64'hFFFF_FFFF_0000_00F0, 1'b1, "R2 clear", 32'h8000_000F, 1'b1, 1'b1);
    do_op(3'b010, 64'h0000_0000_0000_0F00, 1'b1, "R4 clear absent bits", 32'h8000_000F, 1'b0, 1'b0);
  endtask

  task automatic t_write();
    do_op(3'b011, 64'h1234_5678_A5A5_5A5A, 1'b1, "R3 write", 32'hA5A5_5A5A, 1'b1, 1'b1);
    do_op(3'b011, 64'h0000_0000_A5A5_5A5A, 1'b1, "R4 write same", 32'hA5A5_5A5A, 1'b0, 1'b0);
    do_op(3'b001, 64'h0000_0000_0000_0042, 1'b1, "R4 set present bits", 32'hA5A5_5A5A, 1'b0, 1'b0);
  endtask

  task automatic t_enable_off();
    do_op(3'b011, 64'h0, 1'b0, "R6 change with enable low", 32'h0, 1'b1, 1'b0);
    do_op(3'b001, 64'h1, 1'b0, "R6 set with enable low", 32'h1, 1'b1, 1'b0);
  endtask

  task automatic t_ignored();
    for (int k = 4; k < 8; k++) begin
      do_op(3'(k), 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, "R8 ignored opcode", 32'h1, 1'b0, 1'b0);
    end
    do_op(3'b000, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, "R8 idle opcode", 32'h1, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    op = 3'b001; data = 64'h2; irq_en = 1'b1;
    @(negedge clk);
    check("R5 first of pair", pend, chg, rck, 32'h3, 1'b1, 1'b1);
    op = 3'b010; data = 64'h1; irq_en = 1'b0;
    @(negedge clk);
    op = 3'b000;
    check("R6 second of pair", pend, chg, rck, 32'h2, 1'b1, 1'b0);
    @(negedge clk);
    check("R5 pulses end", pend, chg, rck, 32'h2, 1'b0, 1'b0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; exp_pend = '0;
    rst_n = 1'b0; op = 3'b000; data = '0; irq_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset state", pend, chg, rck, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 quiet release", pend, chg, rck, 32'h0, 1'b0, 1'b0);
    t_set();
    t_clear();
    t_write();
    t_enable_off();
    t_ignored();
    t_back_to_back();
    apply_reset();
    do_op(3'b011, 64'h5, 1'b1, "R3 write after reset", 32'h5, 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule